// File: doc/BRIEF.md
# Supply and Fault Protection Sequencer

This block decides when an audio power stage may run. It watches an enable input, a digitized battery voltage in millivolts, a die temperature in degrees Celsius and an over-current flag from the output stage. From these it drives three outputs: a request to precharge the input coupling capacitors, an enable for the amplifier, and a signal that allows the boost converter to run. All timing is counted in ticks of a one-microsecond strobe, so the system clock frequency can be anything above 1 MHz.

A low battery and an overheated die are each held as a lockout with hysteresis. Either lockout shuts everything down. When the lockout clears and enable is high, the block starts again with a fresh precharge. An over-current event stops only the amplifier for a long retry interval while the boost stays available. After that interval the amplifier is tried again, and this repeats for as long as the fault remains. After the battery recovers, enable must stay low for a hold-off window before a start is accepted.

Top module: `supply_guard_seq`

## Requirements
- R1: While reset is asserted and right after it, all three outputs are low, and the battery lockout is active until the battery is first seen at or above the release level.
- R2: A battery reading below UV_TRIP_MV (2100 mV) sets the battery lockout, and all outputs are low two clocks after that reading. A reading of exactly 2100 mV does not trip it.
- R3: The battery lockout clears only on a reading at or above UV_TRIP_MV + UV_HYST_MV (2220 mV). Readings from 2100 to 2219 mV keep it set.
- R4: A temperature at or above OT_TRIP_C (165 °C, signed) sets the thermal lockout, and all outputs are low two clocks later. 164 °C does not trip it.
- R5: The thermal lockout clears only at OT_TRIP_C − OT_HYST_C (140 °C) or below. If enable is high and the hold-off has been met, a fresh precharge then starts.
- R6: After the battery lockout clears, enable must be low for EN_HOLDOFF_US consecutive ticks before a start is accepted. If enable is high earlier, the hold-off count restarts and no start happens.
- R7: Once the hold-off is met, enable is high and there is no lockout, precharge_req is high for exactly PRECHARGE_US ticks, with amp_on and boost_ok low. After that, amp_on and boost_ok go high.
- R8: While the amplifier runs, a high oc_flag drops amp_on on the next clock and keeps it low for OC_RETRY_US ticks. boost_ok stays high during this time.
- R9: When the retry interval ends, amp_on is raised again. If oc_flag is still high, amp_on drops after one clock and a new interval starts. Once oc_flag is low, the amplifier stays on.
- R10: With enable low, all outputs are low one clock later. A lockout during precharge, run or retry returns the block to the off state.
- R11: precharge_req and amp_on are never high together. amp_on rises only after a precharge or a retry interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-clock strobe, once per microsecond |
| en | input | 1 | Enable request |
| vbat_mv | input | VB_W | Battery voltage in millivolts, unsigned |
| temp_c | input | T_W | Die temperature in °C, two's complement |
| oc_flag | input | 1 | Output over-current indication |
| precharge_req | output | 1 | Request to precharge input coupling capacitors |
| amp_on | output | 1 | Amplifier enable |
| boost_ok | output | 1 | Boost converter allowed to run |

## Verification
The bench builds the block with PRECHARGE_US = 20, OC_RETRY_US = 50 and EN_HOLDOFF_US = 10, and keeps the voltage and temperature thresholds at their defaults. The default one-million-tick retry interval would take far too long to run. With the short values, several complete retry loops under a persistent over-current run in a few hundred microseconds, along with the early-enable refusal and repeated restarts after each lockout. The exact threshold and hysteresis edges are tested with the real millivolt and degree values.

// File: rtl/supply_guard_seq.sv
module supply_guard_seq #(
  parameter int VB_W          = 13,
  parameter int T_W           = 10,
  parameter int UV_TRIP_MV    = 2100,
  parameter int UV_HYST_MV    = 120,
  parameter int OT_TRIP_C     = 165,
  parameter int OT_HYST_C     = 25,
  parameter int PRECHARGE_US  = 5000,
  parameter int OC_RETRY_US   = 1000000,
  parameter int EN_HOLDOFF_US = 100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_us,
  input  logic                  en,
  input  logic [VB_W-1:0]       vbat_mv,
  input  logic signed [T_W-1:0] temp_c,
  input  logic                  oc_flag,
  output logic                  precharge_req,
  output logic                  amp_on,
  output logic                  boost_ok
);
  localparam int CNT_MAX = (PRECHARGE_US > OC_RETRY_US) ? PRECHARGE_US : OC_RETRY_US;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam int HW = $clog2(EN_HOLDOFF_US + 1);
  localparam logic [VB_W-1:0] UV_SET = VB_W'(UV_TRIP_MV);
  localparam logic [VB_W-1:0] UV_CLR = VB_W'(UV_TRIP_MV + UV_HYST_MV);
  localparam logic signed [T_W-1:0] OT_SET = T_W'(OT_TRIP_C);
  localparam logic signed [T_W-1:0] OT_CLR = T_W'(OT_TRIP_C - OT_HYST_C);
  localparam logic [CW-1:0] PRE_LAST = CW'(PRECHARGE_US - 1);
  localparam logic [CW-1:0] OC_LAST  = CW'(OC_RETRY_US - 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(EN_HOLDOFF_US - 1);

  typedef enum logic [1:0] {S_OFF, S_PRE, S_RUN, S_RETRY} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hold;
  logic          uv_lock, ot_lock, armed;

  wire fault = uv_lock | ot_lock;
  wire stop  = fault | ~en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_lock <= 1'b1;
      ot_lock <= 1'b0;
    end else begin
      uv_lock <= uv_lock ? (vbat_mv < UV_CLR) : (vbat_mv < UV_SET);
      ot_lock <= ot_lock ? (temp_c > OT_CLR) : (temp_c >= OT_SET);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      hold  <= '0;
    end else if (uv_lock) begin
      armed <= 1'b0;
      hold  <= '0;
    end else if (!armed) begin
      if (en)
        hold <= '0;
      else if (tick_us) begin
        if (hold == HOLD_LAST) armed <= 1'b1;
        else hold <= hold + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_OFF:
          if (!fault && armed && en) begin
            state <= S_PRE;
            cnt   <= '0;
          end
        S_PRE:
          if (stop) state <= S_OFF;
          else if (tick_us) begin
            if (cnt == PRE_LAST) state <= S_RUN;
            else cnt <= cnt + 1'b1;
          end
        S_RUN:
          if (stop) state <= S_OFF;
          else if (oc_flag) begin
            state <= S_RETRY;
            cnt   <= '0;
          end
        S_RETRY:
          if (stop) state <= S_OFF;
          else if (tick_us) begin
            if (cnt == OC_LAST) state <= S_RUN;
            else cnt <= cnt + 1'b1;
          end
        default: state <= S_OFF;
      endcase
    end
  end

  assign precharge_req = (state == S_PRE);
  assign amp_on        = (state == S_RUN);
  assign boost_ok      = (state == S_RUN) || (state == S_RETRY);
endmodule

module supply_guard_seq_chk #(
  parameter int VB_W       = 13,
  parameter int T_W        = 10,
  parameter int UV_TRIP_MV = 2100,
  parameter int OT_TRIP_C  = 165
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en,
  input logic [VB_W-1:0]       vbat_mv,
  input logic signed [T_W-1:0] temp_c,
  input logic                  precharge_req,
  input logic                  amp_on,
  input logic                  boost_ok
);
  a_r2_low_battery_off: assert property (@(posedge clk) disable iff (!rst_n)
    (vbat_mv < VB_W'(UV_TRIP_MV)) |-> ##2 !(precharge_req || amp_on || boost_ok));

  a_r4_hot_die_off: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_c >= $signed(T_W'(OT_TRIP_C))) |-> ##2 !(precharge_req || amp_on || boost_ok));

  a_r10_enable_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(precharge_req || amp_on || boost_ok));

  a_r11_amp_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(amp_on) |-> ($past(precharge_req) || $past(boost_ok)));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({precharge_req, amp_on}));

  a_r8_boost_with_amp: assert property (@(posedge clk) disable iff (!rst_n)
    amp_on |-> boost_ok);

  a_r7_precharge_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(precharge_req) |-> $past(en));
endmodule

bind supply_guard_seq supply_guard_seq_chk #(
  .VB_W(VB_W), .T_W(T_W), .UV_TRIP_MV(UV_TRIP_MV), .OT_TRIP_C(OT_TRIP_C)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .vbat_mv(vbat_mv), .temp_c(temp_c),
  .precharge_req(precharge_req), .amp_on(amp_on), .boost_ok(boost_ok)
);

// File: tb/supply_guard_seq_test.sv
`timescale 1ns/1ps
module supply_guard_seq_test;
  localparam int PRE = 20, RETRY = 50, HOLD = 10;

  logic clk = 0, rst_n = 0, tick_us = 0, en = 0, oc_flag = 0;
  logic [12:0] vbat_mv = 13'd3600;
  logic signed [9:0] temp_c = 10'sd25;
  logic precharge_req, amp_on, boost_ok;

  supply_guard_seq #(.PRECHARGE_US(PRE), .OC_RETRY_US(RETRY), .EN_HOLDOFF_US(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .en(en), .vbat_mv(vbat_mv),
    .temp_c(temp_c), .oc_flag(oc_flag), .precharge_req(precharge_req),
    .amp_on(amp_on), .boost_ok(boost_ok));

  always #2 clk = ~clk;

  int vectors = 0, errors = 0, div = 0;
  bit started = 0, done = 0;
  string cur_req = "R1";

  // behavioural reference: 0 off, 1 precharge, 2 running, 3 retry wait
  int m_st = 0, m_cnt = 0, m_hold = 0;
  bit m_uv = 1, m_ot = 0, m_armed = 0;

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_hold = 0; m_uv = 1; m_ot = 0; m_armed = 0;
    end else begin
      bit bad;
      bad = m_uv || m_ot;
      if (m_st != 0 && (bad || !en)) m_st = 0;
      else if (m_st == 0) begin
        if (!bad && m_armed && en) begin m_st = 1; m_cnt = 0; end
      end else if (m_st == 2) begin
        if (oc_flag) begin m_st = 3; m_cnt = 0; end
      end else if (tick_us) begin
        if (m_cnt + 1 == ((m_st == 1) ? PRE : RETRY)) m_st = 2;
        else m_cnt++;
      end
      if (m_uv) begin m_armed = 0; m_hold = 0; end
      else if (!m_armed) begin
        if (en) m_hold = 0;
        else if (tick_us) begin
          if (m_hold + 1 == HOLD) m_armed = 1; else m_hold++;
        end
      end
      m_uv = m_uv ? (int'(vbat_mv) < 2220) : (int'(vbat_mv) < 2100);
      m_ot = m_ot ? (int'(temp_c) > 140) : (int'(temp_c) >= 165);
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      bit ep, ea, eb;
      ep = (m_st == 1); ea = (m_st == 2); eb = (m_st == 2 || m_st == 3);
      vectors++;
      if ({precharge_req, amp_on, boost_ok} !== {ep, ea, eb}) begin
        errors++;
        $display("FAIL %s t=%0t model: got pre/amp/boost=%b%b%b expected %b%b%b",
                 cur_req, $time, precharge_req, amp_on, boost_ok, ep, ea, eb);
      end
    end
    div = (div + 1) % 4;
    tick_us <= (div == 0);
  end

  task automatic wait_us(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic spot(input bit p, input bit a, input bit b, input string req);
    vectors++;
    if ({precharge_req, amp_on, boost_ok} !== {p, a, b}) begin
      errors++;
      $display("FAIL %s t=%0t spot: got pre/amp/boost=%b%b%b expected %b%b%b",
               req, $time, precharge_req, amp_on, boost_ok, p, a, b);
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    cur_req = "R1";
    repeat (5) @(negedge clk);
    spot(0, 0, 0, "R1");
    rst_n = 1;
    wait_us(2);
    spot(0, 0, 0, "R1");
    // R6: hold-off with enable low, then start
    cur_req = "R6";
    wait_us(HOLD + 3);
    cur_req = "R7";
    en = 1;
    wait_us(10);  spot(1, 0, 0, "R7");
    wait_us(13);  spot(0, 1, 1, "R7");
    // R8 and R9: persistent over-current then recovery
    cur_req = "R8";
    oc_flag = 1;
    wait_us(2);   spot(0, 0, 1, "R8");
    wait_us(40);  spot(0, 0, 1, "R8");
    cur_req = "R9";
    wait_us(130);
    oc_flag = 0;
    wait_us(60);  spot(0, 1, 1, "R9");
    // R2: trip boundary
    cur_req = "R2";
    vbat_mv = 13'd2100;
    wait_us(2);   spot(0, 1, 1, "R2");
    vbat_mv = 13'd2099;
    wait_us(1);   spot(0, 0, 0, "R2");
    // R3: inside hysteresis band stays locked even after hold-off time
    cur_req = "R3";
    en = 0;
    vbat_mv = 13'd2219;
    wait_us(HOLD + 10);
    en = 1;
    wait_us(5);   spot(0, 0, 0, "R3");
    // R6: early enable refused
    cur_req = "R6";
    en = 0;
    vbat_mv = 13'd2220;
    wait_us(5);
    en = 1;
    wait_us(3);   spot(0, 0, 0, "R6");
    en = 0;
    wait_us(HOLD + 2);
    en = 1;
    wait_us(2);   spot(1, 0, 0, "R6");
    cur_req = "R7";
    wait_us(PRE + 3); spot(0, 1, 1, "R7");
    // R4 and R5: thermal edges
    cur_req = "R4";
    temp_c = 10'sd164;
    wait_us(2);   spot(0, 1, 1, "R4");
    temp_c = 10'sd165;
    wait_us(1);   spot(0, 0, 0, "R4");
    cur_req = "R5";
    temp_c = 10'sd141;
    wait_us(5);   spot(0, 0, 0, "R5");
    temp_c = 10'sd140;
    wait_us(2);   spot(1, 0, 0, "R5");
    wait_us(PRE + 3); spot(0, 1, 1, "R5");
    // R10: enable low, and lockouts during precharge and retry
    cur_req = "R10";
    en = 0;
    wait_us(1);   spot(0, 0, 0, "R10");
    en = 1;
    wait_us(2);   spot(1, 0, 0, "R10");
    temp_c = 10'sd180;
    wait_us(1);   spot(0, 0, 0, "R10");
    temp_c = 10'sd25;
    wait_us(PRE + 4); spot(0, 1, 1, "R10");
    oc_flag = 1;
    wait_us(2);   spot(0, 0, 1, "R10");
    temp_c = 10'sd170;
    wait_us(1);   spot(0, 0, 0, "R10");
    oc_flag = 0;
    temp_c = 10'sd25;
    wait_us(2);   spot(1, 0, 0, "R10");
    wait_us(PRE + 3); spot(0, 1, 1, "R11");
    finish_run();
  end
endmodule